// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the six condition and control flags of a small 8-bit accumulator processor: negative, overflow, decimal, interrupt mask, zero and carry. Each cycle the instruction decoder raises at most one operation strobe. The unit then updates the flags from the ALU result, the adder carry and overflow, or the bit a shifter pushed out, following the update rules of that operation class. A pull strobe may come at the same time as another strobe.

For stack traffic the unit always presents the 8-bit image that a push would write. Two bits of that image are not stored anywhere: a constant one, and a source bit that tells an instruction push from a hardware interrupt push. A pull loads the six real flags from a byte and drops the two extra bits. The unit also gates the active-low maskable interrupt line with the mask flag. The non-maskable request bypasses this gate.

Top module: `sf_flags`

## Requirements
- R1: While `rst` is high at a clock edge, the flags become mask=1 and all other flags 0. `flags_o` packs the flags as {N,V,D,I,Z,C}, from bit 5 down to bit 0.
- R2: On an add strobe, C takes `alu_carry_i`, V takes `alu_ovf_i`, Z is set exactly when `result_i` is zero, and N copies `result_i[7]`.
- R3: On a subtract strobe, C takes `alu_carry_i` (1 = no borrow) and V, N and Z update as for add. On a compare strobe, C, N and Z update in the same way and V is left unchanged.
- R4: On a shift strobe, C takes `shift_out_i` and N and Z follow the result. On an increment/decrement strobe or a load strobe, only N and Z change, and C keeps its value.
- R5: On a bit-test strobe, N takes `result_i[7]` and V takes `result_i[6]`. Z, C, D and I keep their values.
- R6: Dedicated strobes set and clear C, I and D. A further strobe clears V, and no strobe sets V. D is stored and read back like any other flag.
- R7: `push_byte_o` is {N,V,1,B,D,I,Z,C}. B is 1 when `push_kind_i` is 0 (instruction push) or 1 (software break), and 0 when it is 2 (maskable interrupt) or 3 (non-maskable interrupt).
- R8: A push strobe with a kind of 1, 2 or 3 sets I. A push strobe with kind 0 leaves all six flags unchanged.
- R9: A pull strobe loads N,V,D,I,Z,C from `result_i` bits 7,6,3,2,1,0 and ignores bits 5 and 4. A pull takes priority over any other strobe raised in the same cycle.
- R10: `irq_req_o` is high exactly when `irq_n_i` is low and I is 0, with no register on this path. It therefore rises in the cycle that I clears while the line is held low.
- R11: The strobe bit positions in `op_i` are: 0 add, 1 subtract, 2 compare, 3 shift, 4 inc/dec, 5 load, 6 bit-test, 7 set C, 8 clear C, 9 set I, 10 clear I, 11 set D, 12 clear D, 13 clear V, 14 push, 15 pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 16 | Operation strobes, at most one per cycle apart from pull |
| result_i | input | 8 | ALU result, bit-test operand, or pulled byte |
| alu_carry_i | input | 1 | Adder carry-out or no-borrow |
| alu_ovf_i | input | 1 | Signed overflow from the adder |
| shift_out_i | input | 1 | Bit shifted or rotated out |
| push_kind_i | input | 2 | Push source: 0 instr, 1 break, 2 irq, 3 nmi |
| irq_n_i | input | 1 | Maskable interrupt line, active low |
| flags_o | output | 6 | Stored flags {N,V,D,I,Z,C} |
| push_byte_o | output | 8 | Status image for a stack write |
| irq_req_o | output | 1 | Gated maskable interrupt request |

## Verification
The assertions assume that the decoder raises at most one strobe other than pull in any cycle. The check on the interrupt gate after a clear-mask strobe also assumes that the interrupt line stays low into the following cycle. The stimulus drives strobes one at a time and combines a second strobe only with pull, which is the case the priority rule covers. The interrupt line is changed only between operations, never on a clock edge.

// File: rtl/sf_pkg.sv
package sf_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 16;

    localparam int OP_ADD  = 0;
    localparam int OP_SUB  = 1;
    localparam int OP_CMP  = 2;
    localparam int OP_SHF  = 3;
    localparam int OP_INC  = 4;
    localparam int OP_LD   = 5;
    localparam int OP_BIT  = 6;
    localparam int OP_SEC  = 7;
    localparam int OP_CLC  = 8;
    localparam int OP_SEI  = 9;
    localparam int OP_CLI  = 10;
    localparam int OP_SED  = 11;
    localparam int OP_CLD  = 12;
    localparam int OP_CLV  = 13;
    localparam int OP_PUSH = 14;
    localparam int OP_PULL = 15;

    typedef enum logic [1:0] {
        PK_INSTR = 2'd0,
        PK_BREAK = 2'd1,
        PK_IRQ   = 2'd2,
        PK_NMI   = 2'd3
    } push_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{n:1'b0, v:1'b0, d:1'b0, i:1'b1, z:1'b0, c:1'b0};

    function automatic logic src_is_instr(input push_kind_e k);
        return (k == PK_INSTR) || (k == PK_BREAK);
    endfunction

    function automatic logic [DATA_W-1:0] pack_image(input flags_t f, input push_kind_e k);
        return {f.n, f.v, 1'b1, src_is_instr(k), f.d, f.i, f.z, f.c};
    endfunction

    function automatic flags_t unpack_byte(input logic [DATA_W-1:0] b);
        flags_t f;
        f.n = b[7];
        f.v = b[6];
        f.d = b[3];
        f.i = b[2];
        f.z = b[1];
        f.c = b[0];
        return f;
    endfunction
endpackage

// File: rtl/sf_next.sv
module sf_next
    import sf_pkg::*;
(
    input  flags_t              cur_i,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DATA_W-1:0]   result_i,
    input  logic                alu_carry_i,
    input  logic                alu_ovf_i,
    input  logic                shift_out_i,
    input  push_kind_e          push_kind_i,
    output flags_t              nxt_o
);
    logic res_zero;
    logic val_op;

    assign res_zero = (result_i == '0);
    assign val_op   = op_i[OP_ADD] | op_i[OP_SUB] | op_i[OP_CMP] | op_i[OP_SHF]
                    | op_i[OP_INC] | op_i[OP_LD];

    always_comb begin
        nxt_o = cur_i;
        if (op_i[OP_PULL]) begin
            nxt_o = unpack_byte(result_i);
        end else begin
            if (val_op) begin
                nxt_o.n = result_i[DATA_W-1];
                nxt_o.z = res_zero;
            end
            if (op_i[OP_ADD] | op_i[OP_SUB]) begin
                nxt_o.c = alu_carry_i;
                nxt_o.v = alu_ovf_i;
            end
            if (op_i[OP_CMP]) nxt_o.c = alu_carry_i;
            if (op_i[OP_SHF]) nxt_o.c = shift_out_i;
            if (op_i[OP_BIT]) begin
                nxt_o.n = result_i[7];
                nxt_o.v = result_i[6];
            end
            if (op_i[OP_SEC]) nxt_o.c = 1'b1;
            if (op_i[OP_CLC]) nxt_o.c = 1'b0;
            if (op_i[OP_SEI]) nxt_o.i = 1'b1;
            if (op_i[OP_CLI]) nxt_o.i = 1'b0;
            if (op_i[OP_SED]) nxt_o.d = 1'b1;
            if (op_i[OP_CLD]) nxt_o.d = 1'b0;
            if (op_i[OP_CLV]) nxt_o.v = 1'b0;
            if (op_i[OP_PUSH] && (push_kind_i != PK_INSTR)) nxt_o.i = 1'b1;
        end
    end
endmodule

// File: rtl/sf_image.sv
module sf_image
    import sf_pkg::*;
(
    input  flags_t              flags_i,
    input  push_kind_e          push_kind_i,
    input  logic                irq_n_i,
    output logic [DATA_W-1:0]   push_byte_o,
    output logic                irq_req_o
);
    assign push_byte_o = pack_image(flags_i, push_kind_i);
    assign irq_req_o   = ~irq_n_i & ~flags_i.i;
endmodule

// File: rtl/sf_flags.sv
module sf_flags
    import sf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_W-1:0]     op_i,
    input  logic [DATA_W-1:0]   result_i,
    input  logic                alu_carry_i,
    input  logic                alu_ovf_i,
    input  logic                shift_out_i,
    input  logic [1:0]          push_kind_i,
    input  logic                irq_n_i,
    output logic [5:0]          flags_o,
    output logic [DATA_W-1:0]   push_byte_o,
    output logic                irq_req_o
);
    localparam logic [OP_W-1:0] PULL_MASK = OP_W'(1) << OP_PULL;

    flags_t     flags_q;
    flags_t     flags_d;
    push_kind_e kind;

    assign kind = push_kind_e'(push_kind_i);

    sf_next u_next (
        .cur_i       (flags_q),
        .op_i        (op_i),
        .result_i    (result_i),
        .alu_carry_i (alu_carry_i),
        .alu_ovf_i   (alu_ovf_i),
        .shift_out_i (shift_out_i),
        .push_kind_i (kind),
        .nxt_o       (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= FLAGS_RESET;
        else     flags_q <= flags_d;
    end

    sf_image u_image (
        .flags_i     (flags_q),
        .push_kind_i (kind),
        .irq_n_i     (irq_n_i),
        .push_byte_o (push_byte_o),
        .irq_req_o   (irq_req_o)
    );

    assign flags_o = flags_q;

    // Input assumption: one strobe at a time besides pull (R11)
    assert_strobes_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_i & ~PULL_MASK));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (flags_o == 6'b000100));

    assert_incdec_keeps_c_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i[OP_INC] && !op_i[OP_PULL]) |=> $stable(flags_o[0]));

    assert_instr_push_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == (OP_W'(1) << OP_PUSH) && push_kind_i == 2'd0) |=> $stable(flags_o));

    assert_intr_push_sets_i_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i[OP_PUSH] && !op_i[OP_PULL] && push_kind_i != 2'd0) |=> flags_o[2]);

    assert_pull_load_R9: assert property (@(posedge clk) disable iff (rst)
        op_i[OP_PULL] |=> (flags_o == {$past(result_i[7:6]), $past(result_i[3:0])}));

    assert_irq_after_cli_R10: assert property (@(posedge clk) disable iff (rst)
        (op_i[OP_CLI] && !op_i[OP_PULL] && !irq_n_i) ##1 !irq_n_i |-> irq_req_o);

    assert_clv_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i[OP_CLV] && !op_i[OP_PULL]) |=> !flags_o[4]);
endmodule

// File: tb/tb_sf_flags.sv
module tb_sf_flags;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] op_i;
    logic [7:0]  result_i;
    logic        alu_carry_i, alu_ovf_i, shift_out_i;
    logic [1:0]  push_kind_i;
    logic        irq_n_i;
    logic [5:0]  flags_o;
    logic [7:0]  push_byte_o;
    logic        irq_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sf_flags dut (
        .clk(clk), .rst(rst), .op_i(op_i), .result_i(result_i),
        .alu_carry_i(alu_carry_i), .alu_ovf_i(alu_ovf_i), .shift_out_i(shift_out_i),
        .push_kind_i(push_kind_i), .irq_n_i(irq_n_i),
        .flags_o(flags_o), .push_byte_o(push_byte_o), .irq_req_o(irq_req_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one operation: bit index, result, carry, overflow, shift bit
    task automatic step(input int bit_i, input logic [7:0] res,
                        input logic c, input logic v, input logic sh);
        op_i = 16'h0;
        op_i[bit_i] = 1'b1;
        result_i = res; alu_carry_i = c; alu_ovf_i = v; shift_out_i = sh;
        @(posedge clk); #1;
        op_i = 16'h0;
    endtask

    task automatic t_reset();
        irq_n_i = 1'b0;
        #1;
        check("R1 reset flags", {2'b0, flags_o}, 8'h04);
        check("R10 masked after reset", {7'b0, irq_req_o}, 8'h00);
    endtask

    task automatic t_cli_irq();
        step(10, 8'h00, 0, 0, 0);
        check("R6 clear I", {2'b0, flags_o}, 8'h00);
        check("R10 irq at once after clear", {7'b0, irq_req_o}, 8'h01);
        irq_n_i = 1'b1; #1;
        check("R10 line high", {7'b0, irq_req_o}, 8'h00);
    endtask

    task automatic t_add();
        step(0, 8'h00, 1, 1, 0);
        check("R2 add zero", {2'b0, flags_o}, 8'h13);
        step(0, 8'h80, 0, 0, 0);
        check("R2 add negative", {2'b0, flags_o}, 8'h20);
    endtask

    task automatic t_sub_cmp();
        step(1, 8'h05, 1, 0, 0);
        check("R3 sub no borrow", {2'b0, flags_o}, 8'h01);
        step(0, 8'h01, 0, 1, 0);
        check("R2 add overflow", {2'b0, flags_o}, 8'h10);
        step(2, 8'h00, 1, 0, 0);
        check("R3 cmp keeps V", {2'b0, flags_o}, 8'h13);
    endtask

    task automatic t_shift_inc();
        step(3, 8'h40, 0, 0, 1);
        check("R4 shift out", {2'b0, flags_o}, 8'h11);
        step(4, 8'h00, 0, 0, 0);
        check("R4 incdec keeps C", {2'b0, flags_o}, 8'h13);
        step(5, 8'hFE, 0, 0, 0);
        check("R4 load N", {2'b0, flags_o}, 8'h31);
    endtask

    task automatic t_bit_strobes();
        step(13, 8'h00, 0, 0, 0);
        check("R6 clear V", {2'b0, flags_o}, 8'h21);
        step(6, 8'h40, 0, 0, 0);
        check("R5 bit test", {2'b0, flags_o}, 8'h11);
        step(6, 8'hC0, 0, 0, 0);
        check("R5 bit test both", {2'b0, flags_o}, 8'h31);
        step(11, 8'h00, 0, 0, 0);
        check("R6 set D", {2'b0, flags_o}, 8'h39);
        step(9, 8'h00, 0, 0, 0);
        check("R6 set I", {2'b0, flags_o}, 8'h3D);
        step(8, 8'h00, 0, 0, 0);
        check("R6 clear C", {2'b0, flags_o}, 8'h3C);
        step(7, 8'h00, 0, 0, 0);
        check("R6 set C", {2'b0, flags_o}, 8'h3D);
    endtask

    task automatic t_image();
        push_kind_i = 2'd0; #1;
        check("R7 image instr", push_byte_o, 8'hFD);
        push_kind_i = 2'd1; #1;
        check("R7 image break", push_byte_o, 8'hFD);
        push_kind_i = 2'd2; #1;
        check("R7 image irq", push_byte_o, 8'hED);
        push_kind_i = 2'd3; #1;
        check("R7 image nmi", push_byte_o, 8'hED);
        step(12, 8'h00, 0, 0, 0);
        check("R6 clear D", {2'b0, flags_o}, 8'h35);
        push_kind_i = 2'd2; #1;
        check("R7 image D clear", push_byte_o, 8'hE5);
    endtask

    task automatic t_push();
        step(10, 8'h00, 0, 0, 0);
        push_kind_i = 2'd0;
        step(14, 8'h00, 0, 0, 0);
        check("R8 instr push stable", {2'b0, flags_o}, 8'h31);
        for (int k = 1; k < 4; k++) begin
            push_kind_i = 2'(k);
            step(14, 8'h00, 0, 0, 0);
            check("R8 push sets I", {2'b0, flags_o}, 8'h35);
            step(10, 8'h00, 0, 0, 0);
        end
    endtask

    task automatic t_pull();
        op_i = 16'h0; op_i[15] = 1'b1; op_i[7] = 1'b1; result_i = 8'h30;
        @(posedge clk); #1; op_i = 16'h0;
        check("R9 pull ignores 5:4 and wins", {2'b0, flags_o}, 8'h00);
        step(15, 8'hCF, 0, 0, 0);
        check("R9 pull all ones", {2'b0, flags_o}, 8'h3F);
        push_kind_i = 2'd0; #1;
        check("R7 image after pull", push_byte_o, 8'hFF);
        irq_n_i = 1'b0; #1;
        check("R10 masked by I", {7'b0, irq_req_o}, 8'h00);
        step(15, 8'h00, 0, 0, 0);
        check("R10 pull clears I", {7'b0, irq_req_o}, 8'h01);
        irq_n_i = 1'b1;
    endtask

    initial begin
        rst = 1'b1; op_i = '0; result_i = '0; alu_carry_i = 0; alu_ovf_i = 0;
        shift_out_i = 0; push_kind_i = 2'd0; irq_n_i = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        t_cli_irq();
        t_add();
        t_sub_cmp();
        t_shift_inc();
        t_bit_strobes();
        t_image();
        t_push();
        t_pull();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule